// File: doc/BRIEF.md
# Indexed Packet Buffer Access Port

This block gives host software one register window onto four small packet buffers (an audio packet and three generic packets) and a separate 48-byte display-capability buffer. A control register picks the packet buffer with a 3-bit index and holds a DWORD access address for packets plus a second DWORD address for the capability buffer. Every read or write through a data window moves the matching address on by one DWORD. The address is 4 bits wide and rolls over from 15 to 0. Bytes past a buffer's valid length are never stored and always read as zero.

The control register also stages a 2-bit transmission mode. The mode is copied into the selected buffer's own mode slot only when word 0 of that buffer is written. It holds three flags owned by software: capability-valid, content-protection ready, and a read-only acknowledge that the audio side raises with a pulse. A transmit engine reads packet words and per-buffer modes through a separate read port. That port never disturbs the software addresses.

Top module: `pktwin_port`

## Requirements
- R1: After reset, a control read returns 0x0100_0000: index 0, both addresses 0, all flags 0, all modes 0, and the size field equal to 16.
- R2: Control word layout: [2:0] buffer index, [5:4] mode, [11:8] packet address, [15:12] capability address, [16] capability-valid, [17] acknowledge (read only), [18] protection ready, [24:20] capability size (read only, always 16). Written fields take effect on the next cycle.
- R3: Bus address 1 is the packet window. It accesses buffer `index[1:0]` at the packet address. Buffer byte k sits in word k/4, lane k%4, with lane 0 in bits 7:0. Each read or write adds 1 to the packet address, and the address wraps from 15 to 0.
- R4: The valid lengths are 13, 11, 31 and 31 bytes for buffers 0 to 3. Bytes at or past the length are dropped on write and read as 0. Words 8 to 15 always read 0.
- R5: An index of the form 1xx is reserved. Packet reads return 0, packet writes change no buffer, the packet address still advances, and the mode field reads 0.
- R6: A packet write at address 0 copies the staged mode from control bits [5:4] into the selected buffer's mode. Writes at other addresses leave it alone. The mode field reads the mode of the buffer that the index selects.
- R7: Bus address 2 is the capability window. It holds 48 bytes addressed by the capability address, which advances by 1 per access and wraps from 15 to 0. Words 12 to 15 drop writes and read 0.
- R8: A one-cycle `aud_ack` pulse sets the acknowledge bit. Writing capability-valid from 1 to 0 clears it, and the clear wins when both happen in the same cycle. Bus writes to bit 17 have no effect.
- R9: Protection ready resets to 0 and holds whatever software last wrote to bit 18.
- R10: `tx_data` shows word `tx_word` of buffer `tx_buf` one cycle later, masked as in R4. `tx_mode` shows that buffer's mode one cycle later. This port never moves either address.
- R11: Read data appears on `bus_rdata` in the cycle after `bus_rd`. Bus address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | 0 control, 1 packet window, 2 capability window, 3 unused |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (ignored while bus_wr is high) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| aud_ack | input | 1 | Audio-side pulse that sets the acknowledge bit |
| tx_buf | input | 2 | Transmit-side buffer select |
| tx_word | input | 3 | Transmit-side word select |
| tx_data | output | 32 | Masked packet word for the transmit side |
| tx_mode | output | 2 | Mode of the transmit-selected buffer |

## Verification
The acknowledge flag has two drivers that can act in the same cycle. A software write that drops capability-valid clears it, and the audio-side pulse sets it. The bench provokes this by issuing the clearing control write on the same clock edge as an `aud_ack` pulse. It then judges a following control read, where bit 17 must be 0. It repeats the pulse alone afterwards to show that the set path still works.

// File: rtl/pktwin_pkg.sv
package pktwin_pkg;
  localparam int DW        = 32;
  localparam int LANES     = DW / 8;
  localparam int IDX_W     = 3;
  localparam int NBUF      = 1 << (IDX_W - 1);
  localparam int BSEL_W    = IDX_W - 1;
  localparam int ADDR_W    = 4;
  localparam int MODE_W    = 2;
  localparam int PKT_SPAN  = 31;
  localparam int PKT_WORDS = (PKT_SPAN + LANES - 1) / LANES;
  localparam int PKT_WAW   = $clog2(PKT_WORDS);
  localparam int CAP_DWORDS = 1 << ADDR_W;
  localparam int SIZE_W    = 5;

  // control word field positions
  localparam int F_IDX_LO   = 0;
  localparam int F_MODE_LO  = 4;
  localparam int F_PADDR_LO = 8;
  localparam int F_CADDR_LO = 12;
  localparam int B_VALID    = 16;
  localparam int B_ACK      = 17;
  localparam int B_CP       = 18;
  localparam int F_SIZE_LO  = 20;

  // bus decode
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_PKT  = 2'd1;
  localparam logic [1:0] A_CAP  = 2'd2;
  localparam logic [1:0] A_NONE = 2'd3;

  // lanes of word w that hold bytes below len
  function automatic logic [LANES-1:0] lane_keep(input logic [ADDR_W-1:0] w, input int len);
    logic [LANES-1:0] k;
    for (int l = 0; l < LANES; l++) k[l] = ((int'(w) * LANES + l) < len);
    return k;
  endfunction

  function automatic logic [DW-1:0] widen(input logic [LANES-1:0] k);
    logic [DW-1:0] m;
    for (int l = 0; l < LANES; l++) m[l*8 +: 8] = {8{k[l]}};
    return m;
  endfunction
endpackage

// File: rtl/pktwin_ram.sv
module pktwin_ram #(
  parameter int DW    = 32,
  parameter int WORDS = 32,
  localparam int AW    = $clog2(WORDS),
  localparam int LANES = DW / 8
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LANES-1:0] wbe,
  input  logic [DW-1:0]    wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rq
);
  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (we && wbe[l]) mem[waddr][l*8 +: 8] <= wdata[l*8 +: 8];
    end
    if (re) rq <= mem[raddr];
  end
endmodule

// File: rtl/pktwin_ctrl.sv
module pktwin_ctrl
  import pktwin_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ctrl_wr,
  input  logic [IDX_W-1:0]       idx_w,
  input  logic [MODE_W-1:0]      mode_w,
  input  logic [ADDR_W-1:0]      paddr_w,
  input  logic [ADDR_W-1:0]      caddr_w,
  input  logic                   valid_w,
  input  logic                   cp_w,
  input  logic                   pkt_acc,
  input  logic                   cap_acc,
  input  logic                   mode_load,
  input  logic                   aud_ack,
  output logic [IDX_W-1:0]       idx_o,
  output logic [ADDR_W-1:0]      paddr_o,
  output logic [ADDR_W-1:0]      caddr_o,
  output logic [NBUF*MODE_W-1:0] modes_o,
  output logic [DW-1:0]          ctrl_word_o
);
  logic [IDX_W-1:0]  idx_q;
  logic [MODE_W-1:0] stage_q;
  logic [ADDR_W-1:0] paddr_q, caddr_q;
  logic              valid_q, ack_q, cp_q;
  logic [MODE_W-1:0] mode_q [NBUF];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      stage_q <= '0;
      paddr_q <= '0;
      caddr_q <= '0;
      valid_q <= 1'b0;
      cp_q    <= 1'b0;
    end else if (ctrl_wr) begin
      idx_q   <= idx_w;
      stage_q <= mode_w;
      paddr_q <= paddr_w;
      caddr_q <= caddr_w;
      valid_q <= valid_w;
      cp_q    <= cp_w;
    end else begin
      if (pkt_acc) paddr_q <= paddr_q + ADDR_W'(1);
      if (cap_acc) caddr_q <= caddr_q + ADDR_W'(1);
    end
  end

  // clear on valid falling edge beats the audio-side set
  always_ff @(posedge clk) begin
    if (rst) ack_q <= 1'b0;
    else if (ctrl_wr && valid_q && !valid_w) ack_q <= 1'b0;
    else if (aud_ack) ack_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NBUF; i++) mode_q[i] <= '0;
    end else if (mode_load) begin
      mode_q[idx_q[BSEL_W-1:0]] <= stage_q;
    end
  end

  for (genvar g = 0; g < NBUF; g++) begin : g_modes
    assign modes_o[g*MODE_W +: MODE_W] = mode_q[g];
  end

  always_comb begin
    ctrl_word_o = '0;
    ctrl_word_o[F_IDX_LO +: IDX_W]    = idx_q;
    ctrl_word_o[F_MODE_LO +: MODE_W]  = idx_q[IDX_W-1] ? '0 : mode_q[idx_q[BSEL_W-1:0]];
    ctrl_word_o[F_PADDR_LO +: ADDR_W] = paddr_q;
    ctrl_word_o[F_CADDR_LO +: ADDR_W] = caddr_q;
    ctrl_word_o[B_VALID]              = valid_q;
    ctrl_word_o[B_ACK]                = ack_q;
    ctrl_word_o[B_CP]                 = cp_q;
    ctrl_word_o[F_SIZE_LO +: SIZE_W]  = SIZE_W'(CAP_DWORDS);
  end

  assign idx_o   = idx_q;
  assign paddr_o = paddr_q;
  assign caddr_o = caddr_q;

  // R3
  paddr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pkt_acc && !ctrl_wr) |=> (paddr_q == $past(paddr_q) + ADDR_W'(1)));

  // R8
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(valid_q) |-> !ack_q);

  // R9
  cp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(ctrl_wr) |-> $stable(cp_q));

  // R6
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_load) |-> $stable(modes_o));
endmodule

// File: rtl/pktwin_port.sv
module pktwin_port
  import pktwin_pkg::*;
#(
  parameter int LEN_AUD   = 13,
  parameter int LEN_G1    = 11,
  parameter int LEN_G2    = 31,
  parameter int LEN_G3    = 31,
  parameter int CAP_BYTES = 48
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic              aud_ack,
  input  logic [BSEL_W-1:0] tx_buf,
  input  logic [PKT_WAW-1:0] tx_word,
  output logic [DW-1:0]     tx_data,
  output logic [MODE_W-1:0] tx_mode
);
  localparam int PKT_RAM_WORDS = NBUF * PKT_WORDS;
  localparam int CAP_RAM_WORDS = 1 << ADDR_W;

  logic ctrl_wr, pkt_wr, pkt_rd, cap_wr, cap_rd, rd_any;
  assign rd_any  = bus_rd && !bus_wr;
  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign pkt_wr  = bus_wr && (bus_addr == A_PKT);
  assign cap_wr  = bus_wr && (bus_addr == A_CAP);
  assign pkt_rd  = rd_any && (bus_addr == A_PKT);
  assign cap_rd  = rd_any && (bus_addr == A_CAP);

  logic [IDX_W-1:0]       idx;
  logic [ADDR_W-1:0]      paddr, caddr;
  logic [NBUF*MODE_W-1:0] modes;
  logic [DW-1:0]          ctrl_word;
  logic                   idx_rsv, mode_load;
  logic [BSEL_W-1:0]      bsel;

  assign idx_rsv   = idx[IDX_W-1];
  assign bsel      = idx[BSEL_W-1:0];
  assign mode_load = pkt_wr && !idx_rsv && (paddr == '0);

  pktwin_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ctrl_wr    (ctrl_wr),
    .idx_w      (bus_wdata[F_IDX_LO +: IDX_W]),
    .mode_w     (bus_wdata[F_MODE_LO +: MODE_W]),
    .paddr_w    (bus_wdata[F_PADDR_LO +: ADDR_W]),
    .caddr_w    (bus_wdata[F_CADDR_LO +: ADDR_W]),
    .valid_w    (bus_wdata[B_VALID]),
    .cp_w       (bus_wdata[B_CP]),
    .pkt_acc    (pkt_wr || pkt_rd),
    .cap_acc    (cap_wr || cap_rd),
    .mode_load  (mode_load),
    .aud_ack    (aud_ack),
    .idx_o      (idx),
    .paddr_o    (paddr),
    .caddr_o    (caddr),
    .modes_o    (modes),
    .ctrl_word_o(ctrl_word)
  );

  function automatic int buf_len(input logic [BSEL_W-1:0] b);
    case (b)
      2'd0:    return LEN_AUD;
      2'd1:    return LEN_G1;
      2'd2:    return LEN_G2;
      default: return LEN_G3;
    endcase
  endfunction

  // packet storage, one copy per read port
  logic [LANES-1:0]   pkt_keep, cap_keep;
  logic               pkt_we;
  logic [PKT_WAW+BSEL_W-1:0] pkt_ba;
  logic [DW-1:0]      pkt_bus_q, pkt_tx_q, cap_q;

  assign pkt_keep = idx_rsv ? '0 : lane_keep(paddr, buf_len(bsel));
  assign cap_keep = lane_keep(caddr, CAP_BYTES);
  assign pkt_we   = pkt_wr && !idx_rsv && (int'(paddr) < PKT_WORDS);
  assign pkt_ba   = {bsel, paddr[PKT_WAW-1:0]};

  for (genvar c = 0; c < 2; c++) begin : g_pkt_copy
    logic [PKT_WAW+BSEL_W-1:0] ra;
    logic                      re;
    logic [DW-1:0]             q;
    assign ra = (c == 0) ? pkt_ba : {tx_buf, tx_word};
    assign re = (c == 0) ? pkt_rd : 1'b1;
    pktwin_ram #(.DW(DW), .WORDS(PKT_RAM_WORDS)) u_ram (
      .clk  (clk),
      .we   (pkt_we),
      .waddr(pkt_ba),
      .wbe  (pkt_keep),
      .wdata(bus_wdata),
      .re   (re),
      .raddr(ra),
      .rq   (q)
    );
  end
  assign pkt_bus_q = g_pkt_copy[0].q;
  assign pkt_tx_q  = g_pkt_copy[1].q;

  pktwin_ram #(.DW(DW), .WORDS(CAP_RAM_WORDS)) u_cap_ram (
    .clk  (clk),
    .we   (cap_wr),
    .waddr(caddr),
    .wbe  (cap_keep),
    .wdata(bus_wdata),
    .re   (cap_rd),
    .raddr(caddr),
    .rq   (cap_q)
  );

  // bus read return
  logic [1:0]       rsel_q;
  logic [DW-1:0]    ctrl_q;
  logic [LANES-1:0] rkeep_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q  <= A_NONE;
      ctrl_q  <= '0;
      rkeep_q <= '0;
    end else if (rd_any) begin
      rsel_q  <= bus_addr;
      ctrl_q  <= ctrl_word;
      rkeep_q <= (bus_addr == A_PKT) ? pkt_keep : cap_keep;
    end
  end

  always_comb begin
    case (rsel_q)
      A_CTRL:  bus_rdata = ctrl_q;
      A_PKT:   bus_rdata = pkt_bus_q & widen(rkeep_q);
      A_CAP:   bus_rdata = cap_q & widen(rkeep_q);
      default: bus_rdata = '0;
    endcase
  end

  // transmit side
  logic [LANES-1:0]  tx_keep_q;
  logic [MODE_W-1:0] tx_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_keep_q <= '0;
      tx_mode_q <= '0;
    end else begin
      tx_keep_q <= lane_keep(ADDR_W'(tx_word), buf_len(tx_buf));
      tx_mode_q <= modes[tx_buf*MODE_W +: MODE_W];
    end
  end

  assign tx_data = pkt_tx_q & widen(tx_keep_q);
  assign tx_mode = tx_mode_q;

  // R2
  size_field_chk: assert property (@(posedge clk) disable iff (rst)
    (rsel_q == A_CTRL) |-> (bus_rdata[F_SIZE_LO +: SIZE_W] == SIZE_W'(CAP_DWORDS)));

  // R10
  addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_rd) && !$past(bus_wr)) |-> ($stable(paddr) && $stable(caddr)));
endmodule

// File: tb/pktwin_port_tb_top.sv
module pktwin_port_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  bus_addr;
  logic        bus_wr, bus_rd;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        aud_ack;
  logic [1:0]  tx_buf;
  logic [2:0]  tx_word;
  logic [31:0] tx_data;
  logic [1:0]  tx_mode;

  int n_chk = 0;
  int n_fail = 0;
  int exp_mode [4];
  logic [31:0] rv;

  always #2 clk = ~clk;

  pktwin_port dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .aud_ack(aud_ack),
    .tx_buf(tx_buf), .tx_word(tx_word), .tx_data(tx_data), .tx_mode(tx_mode)
  );

  function automatic int blen(input int b);
    case (b)
      0: return 13;
      1: return 11;
      default: return 31;
    endcase
  endfunction

  function automatic logic [31:0] kmask(input int w, input int len);
    logic [31:0] m = '0;
    for (int l = 0; l < 4; l++) if (w * 4 + l < len) m[l*8 +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] pat(input int b, input int w);
    return {8'(16 * b + w), 8'(8'h5A ^ w), 8'hC3, 8'(8'h80 + w)};
  endfunction

  function automatic logic [31:0] cpat(input int w);
    return {8'hCA, 8'(w), 8'(8'h0F ^ w), 8'(8'h40 + w)};
  endfunction

  function automatic logic [31:0] mk(input int idx, input int mode, input int pa, input int ca,
                                     input int cv, input int cp);
    return 32'(idx) | (32'(mode) << 4) | (32'(pa) << 8) | (32'(ca) << 12) |
           (32'(cv) << 16) | (32'(cp) << 18);
  endfunction

  function automatic logic [31:0] expc(input int idx, input int mf, input int pa, input int ca,
                                       input int cv, input int ack, input int cp);
    return mk(idx, mf, pa, ca, cv, cp) | (32'(ack) << 17) | (32'd16 << 20);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    rd(2'd0, rv);
    chk("R1 reset control word", rv, 32'h0100_0000);
  endtask

  task automatic t_ctrl_rw;
    wr(2'd0, mk(2, 1, 5, 9, 0, 1) | (32'd1 << 17));
    rd(2'd0, rv);
    chk("R2 R9 control fields", rv, expc(2, 0, 5, 9, 0, 0, 1));
  endtask

  task automatic t_fill;
    for (int b = 0; b < 4; b++) begin
      wr(2'd0, mk(b, b, 0, 0, 0, 0));
      for (int w = 0; w < 8; w++) wr(2'd1, pat(b, w));
      exp_mode[b] = b;
    end
    for (int b = 0; b < 4; b++) begin
      wr(2'd0, mk(b, b, 0, 0, 0, 0));
      for (int w = 0; w < 16; w++) begin
        rd(2'd1, rv);
        chk("R3 R4 packet readback", rv, (w < 8) ? (pat(b, w) & kmask(w, blen(b))) : 32'h0);
      end
      rd(2'd0, rv);
      chk("R3 R6 address wrap and mode", rv, expc(b, b, 0, 0, 0, 0, 0));
    end
  endtask

  task automatic t_reserved;
    wr(2'd0, mk(4, 0, 1, 0, 0, 0));
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd0, rv);
    chk("R5 reserved ctrl", rv, expc(4, 0, 2, 0, 0, 0, 0));
    rd(2'd1, rv);
    chk("R5 reserved read zero", rv, 32'h0);
    wr(2'd0, mk(0, 0, 1, 0, 0, 0));
    rd(2'd1, rv);
    chk("R5 reserved write ignored", rv, pat(0, 1));
  endtask

  task automatic t_mode;
    wr(2'd0, mk(2, 3, 3, 0, 0, 0));
    wr(2'd1, 32'hDEAD_BEEF);
    rd(2'd0, rv);
    chk("R6 mode kept on non-first write", rv, expc(2, 2, 4, 0, 0, 0, 0));
    wr(2'd0, mk(2, 3, 0, 0, 0, 0));
    wr(2'd1, 32'h1234_5678);
    exp_mode[2] = 3;
    rd(2'd0, rv);
    chk("R6 mode captured on first write", rv, expc(2, 3, 1, 0, 0, 0, 0));
    wr(2'd0, mk(1, 0, 0, 0, 0, 0));
    rd(2'd0, rv);
    chk("R6 mode follows index", rv, expc(1, 1, 0, 0, 0, 0, 0));
    wr(2'd0, mk(2, 0, 3, 0, 0, 0));
    rd(2'd1, rv);
    chk("R3 word 3 data", rv, 32'hDEAD_BEEF);
  endtask

  task automatic t_cap;
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
    for (int w = 0; w < 16; w++) wr(2'd2, cpat(w));
    rd(2'd0, rv);
    chk("R7 cap address wrap", rv, expc(0, exp_mode[0], 0, 0, 0, 0, 0));
    for (int w = 0; w < 16; w++) begin
      rd(2'd2, rv);
      chk("R7 cap readback", rv, (w < 12) ? cpat(w) : 32'h0);
    end
  endtask

  task automatic pulse_ack;
    @(negedge clk); aud_ack = 1'b1;
    @(negedge clk); aud_ack = 1'b0;
  endtask

  task automatic t_flags;
    wr(2'd0, mk(0, 0, 0, 0, 1, 0));
    pulse_ack();
    rd(2'd0, rv);
    chk("R8 ack set", rv, expc(0, 0, 0, 0, 1, 1, 0));
    wr(2'd0, mk(0, 0, 0, 0, 1, 0));
    rd(2'd0, rv);
    chk("R8 ack not writable low", rv, expc(0, 0, 0, 0, 1, 1, 0));
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
    rd(2'd0, rv);
    chk("R8 ack cleared by valid fall", rv, expc(0, 0, 0, 0, 0, 0, 0));
    wr(2'd0, mk(0, 0, 0, 0, 1, 0));
    @(negedge clk);
    bus_addr = 2'd0; bus_wr = 1'b1; bus_wdata = mk(0, 0, 0, 0, 0, 0); aud_ack = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; aud_ack = 1'b0;
    rd(2'd0, rv);
    chk("R8 clear wins over ack", rv, expc(0, 0, 0, 0, 0, 0, 0));
    wr(2'd0, mk(0, 0, 0, 0, 0, 0) | (32'd1 << 17));
    rd(2'd0, rv);
    chk("R8 ack not writable high", rv, expc(0, 0, 0, 0, 0, 0, 0));
    pulse_ack();
    rd(2'd0, rv);
    chk("R8 ack set again", rv, expc(0, 0, 0, 0, 0, 1, 0));
    wr(2'd0, mk(0, 0, 0, 0, 0, 1));
    rd(2'd0, rv);
    chk("R9 cp ready set", rv, expc(0, 0, 0, 0, 0, 1, 1));
    wr(2'd0, mk(0, 0, 0, 0, 0, 0));
    rd(2'd0, rv);
    chk("R9 cp ready clear", rv, expc(0, 0, 0, 0, 0, 1, 0));
  endtask

  task automatic tx_probe(input int b, input int w, input logic [31:0] exp_d);
    @(negedge clk); tx_buf = 2'(b); tx_word = 3'(w);
    @(negedge clk);
    chk("R10 tx data", tx_data, exp_d);
    chk("R10 tx mode", 32'(tx_mode), 32'(exp_mode[b]));
  endtask

  task automatic t_tx;
    tx_probe(3, 7, pat(3, 7) & 32'h00FF_FFFF);
    tx_probe(1, 2, pat(1, 2) & 32'h00FF_FFFF);
    tx_probe(0, 3, pat(0, 3) & 32'h0000_00FF);
    tx_probe(2, 3, 32'hDEAD_BEEF);
    rd(2'd0, rv);
    chk("R10 tx leaves addresses", rv, expc(0, 0, 0, 0, 0, 1, 0));
  endtask

  task automatic t_addr3;
    rd(2'd3, rv);
    chk("R11 unused address reads zero", rv, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    aud_ack = 1'b0; tx_buf = '0; tx_word = '0;
    for (int i = 0; i < 4; i++) exp_mode[i] = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_rw();
    t_fill();
    t_reserved();
    t_mode();
    t_cap();
    t_flags();
    t_tx();
    t_addr3();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule